// File: doc/BRIEF.md
# Big-Endian Word Load/Store Unit

This block is the data-memory access stage for word-sized loads and stores. It adds a signed 16-bit displacement to a 32-bit base value to form a byte address. It checks that address for word alignment. It then reads or writes four consecutive bytes of a small internal byte array. The most significant byte of a word sits at the lowest of its four addresses.

An access is requested by raising the load strobe, the store strobe, or both, for one cycle. Store data is written on the rising clock edge. Load data appears combinationally in the same cycle as the load strobe. An access whose address is not a multiple of four is refused: a misalignment flag goes high in that cycle, nothing is written, and the load result is forced to zero. A second, read-only byte port returns any single byte of the array. It is used to confirm where each byte of a stored word ends up.

Top module: `be_lsu`

## Requirements
- R1: The effective address is the base plus the displacement sign-extended to 32 bits, taken modulo 2^32 (e.g. 0xFFFFFFFC + 8 gives 0x00000004, and a displacement of 0xFF10 subtracts 0xF0).
- R2: An access is aligned when bits [1:0] of the effective address are both zero. `misalign_o` is high in exactly those cycles where `ld_i` or `st_i` is high and the address is not aligned.
- R3: An aligned store writes all four bytes at effective addresses EA..EA+3 at the rising clock edge.
- R4: Byte order is big-endian. The byte at EA holds store data bits [31:24], EA+1 holds [23:16], EA+2 holds [15:8] and EA+3 holds [7:0]. An aligned load returns {byte[EA], byte[EA+1], byte[EA+2], byte[EA+3]}.
- R5: A misaligned store leaves every byte of the array unchanged.
- R6: `ld_data_o` is zero whenever `ld_i` is low or the load is misaligned.
- R7: Only the low 8 address bits select a byte of the 256-byte array. Addresses that differ only above bit 7 reach the same byte.
- R8: Reset clears all 256 bytes to zero.
- R9: When an aligned load and an aligned store occur in the same cycle, the load returns the contents as they were before that cycle's store.
- R10: `peek_byte_o` combinationally returns the byte at array index `peek_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed displacement |
| st_data_i | input | 32 | Word to store |
| ld_i | input | 1 | Load strobe |
| st_i | input | 1 | Store strobe |
| ld_data_o | output | 32 | Loaded word |
| misalign_o | output | 1 | Misaligned access flag |
| peek_addr_i | input | 8 | Byte index for the debug read port |
| peek_byte_o | output | 8 | Byte at `peek_addr_i` |

## Verification
A load and a store can be active in the same cycle, which makes the combinational read race the clock-edge write. The bench raises both strobes together at a single aligned address that already holds a known word. It expects that cycle's load to return the old word and a load in the following cycle to return the new one. It also raises both strobes at a misaligned address. There the flag must rise, the load must read zero, and the debug port must show the target bytes untouched.

// File: rtl/be_lsu.sv
module be_lsu #(
  parameter int ADDR_W    = 32,
  parameter int DISP_W    = 16,
  parameter int DATA_W    = 32,
  parameter int MEM_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic              ld_i,
  input  logic              st_i,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              misalign_o,
  input  logic [$clog2(MEM_BYTES)-1:0] peek_addr_i,
  output logic [7:0]        peek_byte_o
);
  localparam int IDX_W  = $clog2(MEM_BYTES);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [ADDR_W-1:0] ea;
  logic              aligned;
  logic [IDX_W-1:0]  wbase;
  logic [7:0]        mem [MEM_BYTES];
  logic [DATA_W-1:0] rword;

  assign ea         = base_i + {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign aligned    = (ea[LANE_W-1:0] == '0);
  assign wbase      = {ea[IDX_W-1:LANE_W], {LANE_W{1'b0}}};
  assign misalign_o = (ld_i | st_i) & ~aligned;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rword[DATA_W-1-8*g -: 8] = mem[wbase | IDX_W'(g)];
  end

  assign ld_data_o   = (ld_i && aligned) ? rword : '0;
  assign peek_byte_o = mem[peek_addr_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
    end else if (st_i && aligned) begin
      for (int l = 0; l < LANES; l++)
        mem[wbase | IDX_W'(l)] <= st_data_i[DATA_W-1-8*l -: 8];
    end
  end
endmodule

// File: rtl/be_lsu_chk.sv
module be_lsu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] base_i,
  input logic [15:0] disp_i,
  input logic [31:0] st_data_i,
  input logic        ld_i,
  input logic        st_i,
  input logic [31:0] ld_data_o,
  input logic        misalign_o,
  input logic [7:0]  peek_addr_i,
  input logic [7:0]  peek_byte_o
);
  logic [31:0] c_ea;
  logic        seen;
  assign c_ea = base_i + {{16{disp_i[15]}}, disp_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  // R2
  a_r2_quiet_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_i || st_i) |-> !misalign_o);

  // R6
  a_r6_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i || misalign_o) |-> ld_data_o == '0);

  // R5
  a_r5_blocked_store: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i && misalign_o && !$isunknown(peek_addr_i)) ##1 $stable(peek_addr_i)
      |-> $stable(peek_byte_o));

  // R4
  a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(st_i && !misalign_o) && peek_addr_i == $past(c_ea[7:0]))
      |-> peek_byte_o == $past(st_data_i[31:24]));

  // R3
  a_r3_word_back: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(st_i && !misalign_o) && ld_i && !misalign_o
      && c_ea[7:0] == $past(c_ea[7:0])) |-> ld_data_o == $past(st_data_i));
endmodule

bind be_lsu be_lsu_chk u_chk (.*);

// File: tb/be_lsu_tb.sv
module be_lsu_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] disp_i = '0;
  logic [31:0] st_data_i = '0;
  logic        ld_i = 1'b0;
  logic        st_i = 1'b0;
  logic [31:0] ld_data_o;
  logic        misalign_o;
  logic [7:0]  peek_addr_i = '0;
  logic [7:0]  peek_byte_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] model [256];

  always #(CLK_P/2) clk = ~clk;

  be_lsu u_dut (.*);

  task automatic chk32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [31:0] b, logic [15:0] d, logic [31:0] w,
                      logic l, logic s, logic [7:0] pk);
    logic [31:0] ea;
    logic        mis;
    logic [31:0] exp_rd;
    logic [7:0]  ix;
    @(negedge clk);
    base_i = b; disp_i = d; st_data_i = w; ld_i = l; st_i = s; peek_addr_i = pk;
    ea  = b + {{16{d[15]}}, d};
    mis = (l || s) && (ea[1:0] != 2'b00);
    ix  = {ea[7:2], 2'b00};
    exp_rd = (l && !mis) ? {model[ix], model[ix+8'd1], model[ix+8'd2], model[ix+8'd3]} : 32'h0;
    #(CLK_P/4);
    chk32(tag, "ld_data", ld_data_o, exp_rd);
    chk32(tag, "misalign", {31'b0, misalign_o}, {31'b0, mis});
    chk32(tag, "peek", {24'b0, peek_byte_o}, {24'b0, model[pk]});
    @(posedge clk);
    if (s && !mis) begin
      model[ix]       = w[31:24];
      model[ix+8'd1]  = w[23:16];
      model[ix+8'd2]  = w[15:8];
      model[ix+8'd3]  = w[7:0];
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    #(CLK_P * 3);
    rst_n = 1'b1;
    // R8 / R10: reset clears the whole array, seen through the peek port
    for (int i = 0; i < 256; i++) step("R8", 0, 0, 0, 1'b0, 1'b0, 8'(i));
    // R3 / R4: aligned store, then peek each lane
    step("R3", 32'h100, 16'h0010, 32'h11223344, 1'b0, 1'b1, 8'h10);
    for (int i = 0; i < 4; i++) step("R4", 0, 0, 0, 1'b0, 1'b0, 8'(8'h10 + i));
    // R1 / R7: negative displacement, high bits alias to same word
    step("R1", 32'h200, 16'hFF10, 0, 1'b1, 1'b0, 8'h10);
    step("R7", 32'hABCD_0000, 16'h0110, 0, 1'b1, 1'b0, 8'h11);
    // R1: wrap-around of the 32-bit sum
    step("R1", 32'hFFFF_FFFC, 16'h0008, 32'hA1B2C3D4, 1'b0, 1'b1, 8'h04);
    step("R1", 32'h0, 16'h0004, 0, 1'b1, 1'b0, 8'h04);
    // R5 / R2: misaligned stores at each bad offset leave bytes alone
    for (int k = 1; k < 4; k++) begin
      step("R5", 32'h110, 16'(k), 32'hDEADBEEF, 1'b0, 1'b1, 8'h11);
      step("R5", 0, 0, 0, 1'b0, 1'b0, 8'(8'h10 + k));
    end
    // R6 / R2: misaligned load reads zero and flags
    step("R6", 32'h110, 16'h0002, 0, 1'b1, 1'b0, 8'h12);
    step("R2", 32'h111, 16'h0000, 0, 1'b1, 1'b0, 8'h13);
    // R9: load and store to the same word in one cycle
    step("R9", 32'h20, 16'h0000, 32'h55667788, 1'b1, 1'b1, 8'h20);
    step("R9", 32'h20, 16'h0000, 32'h99AABBCC, 1'b1, 1'b1, 8'h20);
    step("R9", 32'h20, 16'h0000, 0, 1'b1, 1'b0, 8'h23);
    // R5 / R6: both strobes misaligned
    step("R5", 32'h21, 16'h0000, 32'h01020304, 1'b1, 1'b1, 8'h21);
    step("R5", 32'h20, 16'h0000, 0, 1'b1, 1'b0, 8'h21);
    // R3 / R7: top word of the array and aliasing store
    step("R3", 32'h0000_03FC, 16'h0000, 32'hCAFEF00D, 1'b0, 1'b1, 8'hFC);
    step("R7", 32'h7700_00FC, 16'h0000, 0, 1'b1, 1'b0, 8'hFF);
    for (int i = 0; i < 16; i++)
      step("R4", 32'(i * 4), 16'h0000, 32'h0F1E2D3C ^ 32'(i * 32'h01010101), 1'b1, 1'(i % 2), 8'(i * 4 + 3));
    step("R6", 32'h40, 16'h0000, 0, 1'b0, 1'b0, 8'h40);
    finish_run();
  end
endmodule